// File: doc/BRIEF.md
# Raster horizontal position counter

This block keeps the horizontal position of a video raster. A 9-bit count moves forward by one on every clock where the pixel enable is high. It does not count straight through all 512 codes. Partway along each line it skips ahead to a value that depends on the line width. This makes a line 342 pixels long in the narrow 32-cell mode and 420 pixels long in the wide 40-cell mode. The count still ends every line by rolling over from 0x1FF to 0x000.

Each count value is decoded into exactly one screen-section flag:

- left border
- active picture
- right border
- front porch (the right-hand blanking, which spans the skip)
- horizontal sync
- back porch (which spans the rollover)

An 8-bit external view of the count is also given. A one-clock end-of-line strobe marks the rollover. The width select is taken only at the rollover, so a line never mixes the two sequences.

Top module: `raster_hpos`

## Requirements
- R1: While reset is asserted, and on the first clock after it, hcount is 0x000 and eol is 0. The first line after reset uses the narrow sequence, whatever wide_sel is.
- R2: Narrow mode (wide_sel=0 at the line's rollover) counts 0x000 to 0x127, then goes straight to 0x1D2, then counts up to 0x1FF and rolls over to 0x000. A line is 342 enabled clocks.
- R3: Wide mode (wide_sel=1 at the line's rollover) counts 0x000 to 0x16C, then goes straight to 0x1C9, then counts up to 0x1FF and rolls over. A line is 420 enabled clocks.
- R4: When pix_en is low, hcount keeps its value and eol stays 0.
- R5: hcount_ext always equals hcount bits 8 down to 1.
- R6: Narrow-mode flags for each hcount range:
  - sec_lborder: 0x00B–0x017
  - sec_active: 0x018–0x117
  - sec_rborder: 0x118–0x125
  - sec_fporch: 0x126–0x127 and 0x1D2–0x1D8
  - sec_hsync: 0x1D9–0x1F2
  - sec_bporch: 0x1F3–0x1FF and 0x000–0x00A
- R7: Wide-mode flags for each hcount range:
  - sec_lborder: 0x00D–0x019
  - sec_active: 0x01A–0x159
  - sec_rborder: 0x15A–0x167
  - sec_fporch: 0x168–0x16C and 0x1C9–0x1CC
  - sec_hsync: 0x1CD–0x1EC
  - sec_bporch: 0x1ED–0x1FF and 0x000–0x00C
- R8: Exactly one section flag is high at any time out of reset.
- R9: eol is high for exactly the one clock that follows an enabled rollover from 0x1FF to 0x000. During that clock hcount is 0x000. A count that sits at 0x1FF with pix_en low gives no eol.
- R10: wide_sel is sampled only on an enabled rollover. Changing it partway through a line does not change that line's length or sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel clock enable |
| wide_sel | input | 1 | Width select for the next line: 1 = 40-cell, 0 = 32-cell |
| hcount | output | 9 | Internal horizontal count |
| hcount_ext | output | 8 | External view, hcount[8:1] |
| sec_lborder | output | 1 | Left border section |
| sec_active | output | 1 | Active picture section |
| sec_rborder | output | 1 | Right border section |
| sec_fporch | output | 1 | Front porch / right blanking section |
| sec_hsync | output | 1 | Horizontal sync section |
| sec_bporch | output | 1 | Back porch / left blanking section |
| eol | output | 1 | End-of-line strobe |

## Verification
The hardest cases to reach are a width change written partway through a line and a count parked at 0x1FF with the enable low. Both depend on where the count sits when the input moves.

The stimulus walks the count forward, one enabled pixel at a time, to a chosen position before it changes wide_sel or drops pix_en. It then counts the enabled clocks between end-of-line strobes. This shows that the old line kept its length and the new width took effect only at the next rollover.

// File: rtl/hpos_pkg.sv
package hpos_pkg;

  localparam int CNT_W = 9;
  localparam int EXT_W = CNT_W - 1;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } hmode_e;

  // Section boundaries for one line width
  typedef struct packed {
    logic [CNT_W-1:0] lb_first;
    logic [CNT_W-1:0] act_first;
    logic [CNT_W-1:0] rb_first;
    logic [CNT_W-1:0] fp_first;
    logic [CNT_W-1:0] jump_from;
    logic [CNT_W-1:0] jump_to;
    logic [CNT_W-1:0] hs_first;
    logic [CNT_W-1:0] bp_first;
  } hbounds_t;

  typedef struct packed {
    logic lborder;
    logic active;
    logic rborder;
    logic fporch;
    logic hsync;
    logic bporch;
  } hsect_t;

  function automatic hbounds_t bounds_of(hmode_e m);
    hbounds_t b;
    if (m == MODE_WIDE) begin
      b.lb_first  = CNT_W'(9'h00D);
      b.act_first = CNT_W'(9'h01A);
      b.rb_first  = CNT_W'(9'h15A);
      b.fp_first  = CNT_W'(9'h168);
      b.jump_from = CNT_W'(9'h16C);
      b.jump_to   = CNT_W'(9'h1C9);
      b.hs_first  = CNT_W'(9'h1CD);
      b.bp_first  = CNT_W'(9'h1ED);
    end else begin
      b.lb_first  = CNT_W'(9'h00B);
      b.act_first = CNT_W'(9'h018);
      b.rb_first  = CNT_W'(9'h118);
      b.fp_first  = CNT_W'(9'h126);
      b.jump_from = CNT_W'(9'h127);
      b.jump_to   = CNT_W'(9'h1D2);
      b.hs_first  = CNT_W'(9'h1D9);
      b.bp_first  = CNT_W'(9'h1F3);
    end
    return b;
  endfunction

endpackage

// File: rtl/hpos_rst_sync.sv
module hpos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/hpos_seq.sv
module hpos_seq
  import hpos_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic         wide_sel,
  output logic [W-1:0] cnt,
  output hmode_e       mode,
  output logic         eol
);

  localparam logic [W-1:0] CNT_LAST = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  hmode_e       mode_q, mode_d;
  logic         eol_q, eol_d;
  logic         wrap;
  hbounds_t     bnd;

  always_comb begin
    bnd    = bounds_of(mode_q);
    wrap   = pix_en && (cnt_q == CNT_LAST);
    cnt_d  = cnt_q;
    mode_d = mode_q;
    eol_d  = wrap;
    if (pix_en) begin
      if (cnt_q == bnd.jump_from) begin
        cnt_d = bnd.jump_to;
      end else begin
        cnt_d = W'(cnt_q + 1'b1);
      end
    end
    if (wrap) begin
      mode_d = wide_sel ? MODE_WIDE : MODE_NARROW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= MODE_NARROW;
      eol_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      eol_q  <= eol_d;
    end
  end

  assign cnt  = cnt_q;
  assign mode = mode_q;
  assign eol  = eol_q;

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(cnt_q));

  a_r2_narrow_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode_q == MODE_NARROW && cnt_q == W'(9'h127)) |=> (cnt_q == W'(9'h1D2)));

  a_r3_wide_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode_q == MODE_WIDE && cnt_q == W'(9'h16C)) |=> (cnt_q == W'(9'h1C9)));

  a_r2_no_gap_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NARROW) |-> !(cnt_q > W'(9'h127) && cnt_q < W'(9'h1D2)));

  a_r9_eol_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    eol_q |-> (cnt_q == '0));

  a_r9_eol_single: assert property (@(posedge clk) disable iff (!rst_n)
    eol_q |=> !eol_q);

  a_r10_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && cnt_q == CNT_LAST) |=> $stable(mode_q));

endmodule

// File: rtl/hpos_decode.sv
module hpos_decode
  import hpos_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  hmode_e       mode,
  output hsect_t       sect
);

  hbounds_t bnd;

  always_comb begin
    bnd          = bounds_of(mode);
    sect.lborder = (cnt >= bnd.lb_first)  && (cnt < bnd.act_first);
    sect.active  = (cnt >= bnd.act_first) && (cnt < bnd.rb_first);
    sect.rborder = (cnt >= bnd.rb_first)  && (cnt < bnd.fp_first);
    sect.fporch  = ((cnt >= bnd.fp_first) && (cnt <= bnd.jump_from)) ||
                   ((cnt >= bnd.jump_to)  && (cnt < bnd.hs_first));
    sect.hsync   = (cnt >= bnd.hs_first)  && (cnt < bnd.bp_first);
    sect.bporch  = (cnt >= bnd.bp_first)  || (cnt < bnd.lb_first);
  end

  a_r8_one_section: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sect) == 1);

  a_r6_r7_sync_after_porch: assert property (@(posedge clk) disable iff (!rst_n)
    (sect.hsync && $past(sect.fporch)) |-> (cnt == bnd.hs_first));

endmodule

// File: rtl/raster_hpos.sv
module raster_hpos
  import hpos_pkg::*;
#(
  parameter int W        = CNT_W,
  parameter int SYNC_STG = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic           wide_sel,
  output logic [W-1:0]   hcount,
  output logic [W-2:0]   hcount_ext,
  output logic           sec_lborder,
  output logic           sec_active,
  output logic           sec_rborder,
  output logic           sec_fporch,
  output logic           sec_hsync,
  output logic           sec_bporch,
  output logic           eol
);

  logic   rst_n_int;
  hmode_e line_mode;
  hsect_t sect;

  hpos_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hpos_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pix_en   (pix_en),
    .wide_sel (wide_sel),
    .cnt      (hcount),
    .mode     (line_mode),
    .eol      (eol)
  );

  hpos_decode #(.W(W)) u_decode (
    .clk   (clk),
    .rst_n (rst_n_int),
    .cnt   (hcount),
    .mode  (line_mode),
    .sect  (sect)
  );

  assign hcount_ext  = hcount[W-1:1];
  assign sec_lborder = sect.lborder;
  assign sec_active  = sect.active;
  assign sec_rborder = sect.rborder;
  assign sec_fporch  = sect.fporch;
  assign sec_hsync   = sect.hsync;
  assign sec_bporch  = sect.bporch;

endmodule

// File: tb/raster_hpos_bench.sv
module raster_hpos_bench;

  logic       clk;
  logic       rst_n;
  logic       pix_en;
  logic       wide_sel;
  logic [8:0] hcount;
  logic [7:0] hcount_ext;
  logic       sec_lborder, sec_active, sec_rborder, sec_fporch, sec_hsync, sec_bporch;
  logic       eol;

  int n_chk = 0;
  int n_bad = 0;

  raster_hpos u_raster_hpos (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .wide_sel    (wide_sel),
    .hcount      (hcount),
    .hcount_ext  (hcount_ext),
    .sec_lborder (sec_lborder),
    .sec_active  (sec_active),
    .sec_rborder (sec_rborder),
    .sec_fporch  (sec_fporch),
    .sec_hsync   (sec_hsync),
    .sec_bporch  (sec_bporch),
    .eol         (eol)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Flag codes: [5] lborder [4] active [3] rborder [2] fporch [1] hsync [0] bporch
  localparam logic [5:0] F_LB = 6'b100000, F_AC = 6'b010000, F_RB = 6'b001000,
                         F_FP = 6'b000100, F_HS = 6'b000010, F_BP = 6'b000001;

  // {wide, position, expected flags}
  localparam logic [15:0] VECS [0:31] = '{
    {1'b0, 9'h000, F_BP}, {1'b0, 9'h00A, F_BP}, {1'b0, 9'h00B, F_LB}, {1'b0, 9'h017, F_LB},
    {1'b0, 9'h018, F_AC}, {1'b0, 9'h117, F_AC}, {1'b0, 9'h118, F_RB}, {1'b0, 9'h125, F_RB},
    {1'b0, 9'h126, F_FP}, {1'b0, 9'h127, F_FP}, {1'b0, 9'h1D2, F_FP}, {1'b0, 9'h1D8, F_FP},
    {1'b0, 9'h1D9, F_HS}, {1'b0, 9'h1F2, F_HS}, {1'b0, 9'h1F3, F_BP}, {1'b0, 9'h1FF, F_BP},
    {1'b1, 9'h000, F_BP}, {1'b1, 9'h00C, F_BP}, {1'b1, 9'h00D, F_LB}, {1'b1, 9'h019, F_LB},
    {1'b1, 9'h01A, F_AC}, {1'b1, 9'h159, F_AC}, {1'b1, 9'h15A, F_RB}, {1'b1, 9'h167, F_RB},
    {1'b1, 9'h168, F_FP}, {1'b1, 9'h16C, F_FP}, {1'b1, 9'h1C9, F_FP}, {1'b1, 9'h1CC, F_FP},
    {1'b1, 9'h1CD, F_HS}, {1'b1, 9'h1EC, F_HS}, {1'b1, 9'h1ED, F_BP}, {1'b1, 9'h1FF, F_BP}
  };

  function automatic logic [5:0] flags();
    return {sec_lborder, sec_active, sec_rborder, sec_fporch, sec_hsync, sec_bporch};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive pix_en just after a rising edge, then sample 1 ns after the next one
  task automatic tick(input logic en);
    pix_en = en;
    @(posedge clk);
    #1;
  endtask

  task automatic step_to(input logic [8:0] target);
    for (int i = 0; i < 600 && hcount !== target; i++) tick(1'b1);
  endtask

  task automatic to_eol();
    for (int i = 0; i < 600; i++) begin
      tick(1'b1);
      if (eol === 1'b1) break;
    end
  endtask

  task automatic line_len(output int n);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      tick(1'b1);
      n++;
      if (eol === 1'b1) break;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n    = 1'b0;
    pix_en   = 1'b0;
    wide_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset hcount", 32'(hcount), 0);
    check("R1 reset eol", 32'(eol), 0);
    check("R1 reset ext", 32'(hcount_ext), 0);
    rst_n = 1'b1;
    repeat (3) tick(1'b0);
    check("R1 hcount after release", 32'(hcount), 0);

    // R1 / R10: first line narrow even with wide_sel=1, next line wide
    line_len(n);
    check("R1 first line narrow length", 32'(n), 342);
    check("R9 eol at zero", 32'(hcount), 0);
    tick(1'b0);
    check("R9 eol single clock", 32'(eol), 0);
    line_len(n);
    check("R3 wide line length", 32'(n), 420);

    // Table walk: R5, R6, R7
    wide_sel = 1'b0;
    to_eol();
    for (int v = 0; v < 32; v++) begin
      logic       vw;
      logic [8:0] vp;
      logic [5:0] vf;
      {vw, vp, vf} = VECS[v];
      if (wide_sel !== vw || hcount > vp) begin
        wide_sel = vw;
        to_eol();
      end
      step_to(vp);
      check(vw ? "R7 position" : "R6 position", 32'(hcount), 32'(vp));
      check(vw ? "R7 section flags" : "R6 section flags", 32'(flags()), 32'(vf));
      check("R8 one flag", 32'($countones(flags())), 1);
      check("R5 external value", 32'(hcount_ext), 32'(vp >> 1));
    end

    // R2 / R3 jumps
    wide_sel = 1'b0;
    to_eol();
    step_to(9'h127);
    tick(1'b1);
    check("R2 narrow jump", 32'(hcount), 32'h1D2);
    wide_sel = 1'b1;
    to_eol();
    step_to(9'h16C);
    tick(1'b1);
    check("R3 wide jump", 32'(hcount), 32'h1C9);

    // R4 hold
    step_to(9'h1E0);
    repeat (5) tick(1'b0);
    check("R4 hold count", 32'(hcount), 32'h1E0);
    check("R4 hold eol", 32'(eol), 0);

    // R9 no eol while parked at 0x1FF
    step_to(9'h1FF);
    repeat (3) tick(1'b0);
    check("R9 parked at last", 32'(hcount), 32'h1FF);
    check("R9 no eol when disabled", 32'(eol), 0);
    tick(1'b1);
    check("R9 eol on wrap", 32'(eol), 1);
    tick(1'b0);
    check("R9 eol drops", 32'(eol), 0);
    check("R4 zero held", 32'(hcount), 0);

    // R10 mid-line change: wide line keeps 420, next is narrow
    for (int i = 0; i < 100; i++) tick(1'b1);
    wide_sel = 1'b0;
    line_len(n);
    check("R10 mid-line change ignored", 32'(n + 100), 420);
    line_len(n);
    check("R2 narrow line length", 32'(n), 342);

    // R1 asynchronous reset mid-line
    step_to(9'h050);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async reset count", 32'(hcount), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick(1'b0);
    check("R1 held after reset", 32'(hcount), 0);

    summary();
    $finish;
  end

endmodule